// File: doc/BRIEF.md
# Nibble-RAM Cartridge Bank Controller

This block sits between a CPU bus and a cartridge memory set. It keeps a RAM-enable flag and a 4-bit ROM bank register, turns CPU addresses in the two ROM windows into a linear address for the external ROM array, and holds a small 512 x 4-bit RAM of its own that the CPU reaches through the external RAM window.

Control writes all land in the lower 16 KiB of the address map. The controller does not split that area into separate register ranges. Address bit 8 alone picks which register a write updates. The on-chip RAM keeps only a nibble per location. Its 512 locations repeat across the whole 8 KiB RAM window, so any address there reaches location `addr[8:0]`.

The number of ROM banks is a configuration input. Bank writes wrap modulo that count, and a result of zero is forced to bank 1. Reads are combinational from the current address. Writes take effect on the rising clock edge on which `bus_wr` is high.

Top module: `nibble_bank_ctrl`

## Requirements
- R1: A write in 0x0000-0x3FFF with address bit 8 set goes to the ROM bank register. With bit 8 clear it goes to the RAM-enable flag. Neither write touches the other register.
- R2: A RAM-enable write looks only at data bits 3:0. The value 0x0 clears the flag, 0xA sets it, and any other value leaves it unchanged.
- R3: A ROM bank write takes data bits 3:0 modulo `bank_count` (valid range 1 to 16). A result of 0 selects bank 1.
- R4: For a CPU address in 0x4000-0x7FFF, `rom_addr` equals bank x 0x4000 + addr[13:0].
- R5: For a CPU address in 0x0000-0x3FFF, `rom_addr` equals addr[13:0], which is bank 0, whatever the bank register holds.
- R6: The internal RAM has 512 locations indexed by addr[8:0] and is mirrored through all of 0xA000-0xBFFF.
- R7: A RAM write stores data bits 3:0. A read of an enabled RAM returns that nibble in bits 3:0 with bits 7:4 at zero.
- R8: While the RAM-enable flag is clear, reads in 0xA000-0xBFFF return 0xFF and writes there leave the RAM unchanged.
- R9: Writes to 0x4000-0x7FFF change neither the bank register nor the RAM-enable flag.
- R10: After a synchronous active-low reset, the RAM-enable flag is clear and the bank register holds 1.
- R11: `ram_rdata` is 0xFF for any address outside 0xA000-0xBFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | CPU address |
| bus_wdata | input | 8 | CPU write data |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bank_count | input | 5 | Number of ROM banks, 1 to 16 |
| rom_addr | output | 18 | Linear address into the external ROM array |
| ram_rdata | output | 8 | Read data from the internal RAM window |

## Verification
The assertions assume that `bank_count` stays between 1 and 16, and one of them checks that directly. They also assume the count is not changed in the same cycle as a bank write, since the load check compares the stored bank against the count from that cycle. The readback check further assumes that the address and write strobe are driven between clock edges and held for a full cycle. The bench keeps to these rules: it drives every input on the falling edge, changes the count only in cycles with no write, and never uses a count outside 1 to 16.

// File: rtl/nbc_pkg.sv
// Package nbc_pkg
// Purpose : shared address-region type and decode for the nibble-RAM
//           bank controller.
// Assumes : a 16-bit CPU address space with 16 KiB ROM windows and an
//           8 KiB external RAM window at 0xA000.
package nbc_pkg;

    typedef enum logic [1:0] {
        RGN_FIXED  = 2'd0,   // 0x0000-0x3FFF: fixed ROM, control writes
        RGN_SWITCH = 2'd1,   // 0x4000-0x7FFF: switchable ROM
        RGN_RAM    = 2'd2,   // 0xA000-0xBFFF: internal RAM window
        RGN_NONE   = 2'd3    // everything else
    } region_e;

    localparam int ROM_WIN_W = 14;   // 16 KiB window offset width

    // Classify a CPU address by its top three bits.
    function automatic region_e decode_region(input logic [2:0] top3);
        case (top3)
            3'b000, 3'b001: decode_region = RGN_FIXED;
            3'b010, 3'b011: decode_region = RGN_SWITCH;
            3'b101:         decode_region = RGN_RAM;
            default:        decode_region = RGN_NONE;
        endcase
    endfunction

endpackage

// File: rtl/nbc_ctrl_regs.sv
// Module  : nbc_ctrl_regs
// Purpose : holds the RAM-enable flag and the ROM bank register. It wraps
//           bank writes modulo the bank count and forces a zero result to 1.
// Assumes : wr_en is asserted only for writes in the control range. sel_bank
//           is address bit 8. bank_count lies in 1..2**BANK_W.
module nbc_ctrl_regs #(
    parameter int BANK_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              sel_bank,
    input  logic [3:0]        wnib,
    input  logic [BANK_W:0]   bank_count,
    output logic              ram_on,
    output logic [BANK_W-1:0] bank_q
);
    localparam logic [3:0] NIB_OFF = 4'h0;
    localparam logic [3:0] NIB_ON  = 4'hA;
    localparam logic [BANK_W-1:0] BANK_ONE = BANK_W'(1);

    logic [BANK_W:0]   raw_bank;
    logic [BANK_W:0]   wrapped;
    logic [BANK_W-1:0] bank_next;

    // Wrap the requested bank modulo the count and replace 0 with 1.
    always_comb begin
        raw_bank  = (BANK_W+1)'(wnib);
        wrapped   = (bank_count == '0) ? raw_bank : (raw_bank % bank_count);
        bank_next = (wrapped == '0) ? BANK_ONE : wrapped[BANK_W-1:0];
    end

    // Load the bank register on a bank-select write.
    always_ff @(posedge clk) begin
        if (!rst_n)                  bank_q <= BANK_ONE;
        else if (wr_en && sel_bank)  bank_q <= bank_next;
    end

    // Update the enable flag on the two recognised nibble values only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_on <= 1'b0;
        end else if (wr_en && !sel_bank) begin
            if (wnib == NIB_OFF)     ram_on <= 1'b0;
            else if (wnib == NIB_ON) ram_on <= 1'b1;
        end
    end

    assert_bank_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bank_q != '0);

    assert_bank_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel_bank && wnib != 4'h0 && (BANK_W+1)'(wnib) < bank_count)
        |=> bank_q == BANK_W'($past(wnib)));

    assert_en_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_bank && wnib != NIB_OFF && wnib != NIB_ON) |=> $stable(ram_on));

    assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sel_bank && wnib == NIB_ON) |=> ram_on);

    assert_bank_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && sel_bank)) |=> $stable(bank_q));

endmodule

// File: rtl/nbc_nibble_ram.sv
// Module  : nbc_nibble_ram
// Purpose : internal RAM of DEPTH locations, each NIB_W bits wide. It has
//           a synchronous write and a combinational read.
// Assumes : the caller supplies an address already reduced to AW bits and
//           gates we with the enable flag. The contents are not reset.
module nbc_nibble_ram #(
    parameter int DEPTH = 512,
    parameter int NIB_W = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [NIB_W-1:0] din,
    output logic [NIB_W-1:0] dout
);
    logic [NIB_W-1:0] mem [DEPTH];

    // Store one nibble on a gated write.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= din;
    end

    // Return the addressed location.
    assign dout = mem[addr];

endmodule

// File: rtl/nbc_rom_map.sv
// Module  : nbc_rom_map
// Purpose : forms the linear ROM address. The fixed window maps to bank 0
//           and the switchable window to the current bank.
// Assumes : the region has been decoded from the same address. Addresses
//           outside both ROM windows yield zero.
module nbc_rom_map #(
    parameter int BANK_W = 4,
    parameter int WIN_W  = nbc_pkg::ROM_WIN_W,
    localparam int OUT_W = BANK_W + WIN_W
) (
    input  nbc_pkg::region_e  region,
    input  logic [WIN_W-1:0]  offset,
    input  logic [BANK_W-1:0] bank,
    output logic [OUT_W-1:0]  rom_addr
);
    import nbc_pkg::*;

    // Choose the bank field according to the window.
    always_comb begin
        case (region)
            RGN_FIXED:  rom_addr = {{BANK_W{1'b0}}, offset};
            RGN_SWITCH: rom_addr = {bank, offset};
            default:    rom_addr = '0;
        endcase
    end

endmodule

// File: rtl/nibble_bank_ctrl.sv
// Module  : nibble_bank_ctrl
// Purpose : top level of the nibble-RAM bank controller. It decodes the CPU
//           address, steers control writes by address bit 8, maps the ROM
//           windows and serves the mirrored nibble RAM.
// Assumes : the bus is single-cycle and writes commit on the rising edge.
//           bank_count lies in 1..2**BANK_W and is held steady during writes.
module nibble_bank_ctrl #(
    parameter int BANK_W    = 4,
    parameter int RAM_DEPTH = 512,
    parameter int NIB_W     = 4,
    localparam int WIN_W    = nbc_pkg::ROM_WIN_W,
    localparam int ROM_AW   = BANK_W + WIN_W,
    localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic [BANK_W:0]   bank_count,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [7:0]        ram_rdata
);
    import nbc_pkg::*;

    region_e           region;
    logic [3:0]        wnib;
    logic              ctrl_wr;
    logic              ram_we;
    logic              ram_on;
    logic [BANK_W-1:0] bank_q;
    logic [NIB_W-1:0]  ram_dout;

    // Decode the region and qualify write strobes.
    always_comb begin
        region  = decode_region(bus_addr[15:13]);
        wnib    = 4'(bus_wdata & 8'h0F);
        ctrl_wr = bus_wr && (region == RGN_FIXED);
        ram_we  = bus_wr && (region == RGN_RAM) && ram_on;
    end

    nbc_ctrl_regs #(.BANK_W(BANK_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (ctrl_wr),
        .sel_bank   (bus_addr[8]),
        .wnib       (wnib),
        .bank_count (bank_count),
        .ram_on     (ram_on),
        .bank_q     (bank_q)
    );

    nbc_nibble_ram #(.DEPTH(RAM_DEPTH), .NIB_W(NIB_W)) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .addr (bus_addr[RAM_AW-1:0]),
        .din  (wnib[NIB_W-1:0]),
        .dout (ram_dout)
    );

    nbc_rom_map #(.BANK_W(BANK_W), .WIN_W(WIN_W)) u_map (
        .region   (region),
        .offset   (bus_addr[WIN_W-1:0]),
        .bank     (bank_q),
        .rom_addr (rom_addr)
    );

    // Return the zero-extended nibble only for an enabled RAM window.
    always_comb begin
        if (region == RGN_RAM && ram_on) ram_rdata = {{(8-NIB_W){1'b0}}, ram_dout};
        else                              ram_rdata = 8'hFF;
    end

    assert_count_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bank_count != '0 && bank_count <= (BANK_W+1)'(1 << BANK_W));

    assert_disabled_ff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_RAM && !ram_on) |-> ram_rdata == 8'hFF);

    assert_upper_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (region == RGN_RAM && ram_on) |-> ram_rdata[7:4] == 4'h0);

    assert_fixed_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:14] == 2'b00) |-> rom_addr == ROM_AW'(bus_addr[13:0]));

    assert_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> (!$stable(bus_addr) || !ram_on ||
                    ram_rdata == {4'h0, $past(bus_wdata[3:0])}));

    assert_outside_ff_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr[15:13] != 3'b101) |-> ram_rdata == 8'hFF);

endmodule

// File: tb/tb_nibble_bank_ctrl.sv
// Directed bench for nibble_bank_ctrl. Each task covers one scenario and
// checks its own results. Inputs change on the falling edge.
module tb_nibble_bank_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0;
    logic [4:0]  bank_count = 5'd16;
    logic [17:0] rom_addr;
    logic [7:0]  ram_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    nibble_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bank_count(bank_count),
        .rom_addr(rom_addr), .ram_rdata(ram_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic look(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        #1;
    endtask

    task automatic set_count(input logic [4:0] c);
        @(negedge clk);
        bank_count = c;
    endtask

    task automatic t_reset;
        look(16'hA000); check("R10 ram off after reset", ram_rdata, 8'hFF);
        look(16'h4000); check("R10 bank one after reset", rom_addr, 18'h04000);
    endtask

    task automatic t_steer;
        wr(16'h0100, 8'h0A);
        look(16'h4001); check("R1 bit8 set loads bank", rom_addr, 18'h28001);
        look(16'hA000); check("R1 bit8 set leaves ram off", ram_rdata, 8'hFF);
        wr(16'h0000, 8'h0A);
        look(16'h4001); check("R1 bit8 clear leaves bank", rom_addr, 18'h28001);
    endtask

    task automatic t_enable;
        wr(16'hA010, 8'h06);
        wr(16'h0000, 8'h00);
        look(16'hA010); check("R2 zero disables", ram_rdata, 8'hFF);
        wr(16'h1E00, 8'h3A);
        look(16'hA010); check("R2 upper nibble ignored on enable", ram_rdata, 8'h06);
        wr(16'h0000, 8'h05);
        look(16'hA010); check("R2 other value holds on", ram_rdata, 8'h06);
        wr(16'h0000, 8'hF0);
        look(16'hA010); check("R2 low zero disables", ram_rdata, 8'hFF);
        wr(16'h0000, 8'h07);
        look(16'hA010); check("R2 other value holds off", ram_rdata, 8'hFF);
        wr(16'h0000, 8'h0A);
    endtask

    task automatic t_bank;
        wr(16'h2100, 8'h05);
        look(16'h4123); check("R4 bank 5 address", rom_addr, 18'h14123);
        look(16'h7FFF); check("R4 window top", rom_addr, 18'h17FFF);
        wr(16'h2100, 8'hF0);
        look(16'h4000); check("R3 zero becomes one", rom_addr, 18'h04000);
        set_count(5'd8);
        wr(16'h2100, 8'h0B);
        look(16'h4000); check("R3 11 mod 8", rom_addr, 18'h0C000);
        wr(16'h2100, 8'h08);
        look(16'h4000); check("R3 8 mod 8 gives 1", rom_addr, 18'h04000);
        set_count(5'd6);
        wr(16'h2100, 8'h0D);
        look(16'h4000); check("R3 13 mod 6", rom_addr, 18'h04000);
        wr(16'h2100, 8'h0B);
        look(16'h4000); check("R3 11 mod 6", rom_addr, 18'h14000);
        set_count(5'd1);
        wr(16'h2100, 8'h05);
        look(16'h4000); check("R3 single bank", rom_addr, 18'h04000);
        set_count(5'd16);
        wr(16'h3FFF, 8'h0F);
        look(16'h4000); check("R3 bank 15", rom_addr, 18'h3C000);
    endtask

    task automatic t_fixed;
        look(16'h3ABC); check("R5 fixed window bank 0", rom_addr, 18'h03ABC);
        look(16'h0000); check("R5 fixed window base", rom_addr, 18'h00000);
    endtask

    task automatic t_ram;
        wr(16'hA000, 8'hC7);
        look(16'hA000); check("R7 low nibble stored", ram_rdata, 8'h07);
        look(16'hA200); check("R6 mirror A200", ram_rdata, 8'h07);
        look(16'hBE00); check("R6 mirror BE00", ram_rdata, 8'h07);
        wr(16'hA1FF, 8'h3E);
        look(16'hBFFF); check("R6 last location mirror", ram_rdata, 8'h0E);
        wr(16'hB201, 8'h55);
        look(16'hA001); check("R6 mirrored write", ram_rdata, 8'h05);
        look(16'hA000); check("R6 neighbour kept", ram_rdata, 8'h07);
    endtask

    task automatic t_disabled;
        wr(16'h0000, 8'h00);
        wr(16'hA000, 8'h09);
        look(16'hA000); check("R8 read FF while off", ram_rdata, 8'hFF);
        wr(16'h0000, 8'h0A);
        look(16'hA000); check("R8 write ignored while off", ram_rdata, 8'h07);
    endtask

    task automatic t_ignored;
        wr(16'h2100, 8'h03);
        wr(16'h4000, 8'h00);
        wr(16'h6100, 8'h05);
        wr(16'h7FFF, 8'h00);
        look(16'h4000); check("R9 bank unchanged", rom_addr, 18'h0C000);
        look(16'hA000); check("R9 ram still on", ram_rdata, 8'h07);
    endtask

    task automatic t_outside;
        look(16'h8000); check("R11 8000 reads FF", ram_rdata, 8'hFF);
        look(16'hC000); check("R11 C000 reads FF", ram_rdata, 8'hFF);
        look(16'h1234); check("R11 low area reads FF", ram_rdata, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_steer();
        t_enable();
        t_bank();
        t_fixed();
        t_ram();
        t_disabled();
        t_ignored();
        t_outside();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule